// File: doc/BRIEF.md
# Programming-Mode Entry Key Detector

This block decides whether a device enters its program/verify mode. It watches three slow external lines, each brought into the system clock domain by its own synchronizer: the reset/programming-voltage pin (already reduced to a logic level), the serial clock and the serial data. A valid entry has four parts in order. First the pin pulses high and then low. After a pre-key wait, a 32-bit key is clocked in most-significant bit first and must equal 32'h4D434851. Finally the pin returns high and stays there. Only then does the mode-active output rise.

After entry there is a settle window. Serial clock edges that arrive in this window are discarded. Once the window has passed, every rising serial clock edge is handed on as a one-cycle pulse, together with the data bit, to the command engine that sits downstream. If the pin drops low at any time while the mode is active, the mode ends. A wrong key sends the detector back to idle, and it then needs a fresh high-low pulse on the pin before it will accept another key.

The controller has eight named states:

| State | Meaning |
|---|---|
| ST_IDLE | Waiting for the pin to go high. |
| ST_PULSE_HI | The pin is high and the opening pulse is in progress. |
| ST_GAP | The pre-key wait is running and serial edges are discarded. |
| ST_KEY | Key bits are being collected. |
| ST_CHECK | The collected word is being compared with the key. |
| ST_ARM | The key matched and the block waits for the pin to rise. |
| ST_SETTLE | The mode is active and serial edges are still discarded. |
| ST_ACTIVE | The mode is active and serial edges are passed on. |

The transitions are:

- IDLE to PULSE_HI when the pin is high.
- PULSE_HI to GAP when the pin is low.
- GAP to PULSE_HI when the pin is high, and GAP to KEY when the pre-key wait has expired.
- KEY to PULSE_HI when the pin is high, and KEY to CHECK when 32 bits have been collected.
- CHECK to ARM on a match, and CHECK to IDLE on a mismatch.
- ARM to SETTLE when the pin is high.
- SETTLE to IDLE when the pin is low, and SETTLE to ACTIVE when the settle window has expired.
- ACTIVE to IDLE when the pin is low.

Top module: `entry_key_detector`

## Requirements
- R1: While reset is asserted and right after it is released, mode_active_o and cmd_edge_o are 0.
- R2: The sequence is a high-low pulse on the pin, a wait of PRE_CYC cycles, 32 key bits equal to 32'h4D434851 sent MSb first, and then the pin going high. After this sequence mode_active_o goes to 1, on the third rising clock edge after the pin goes high.
- R3: If any key bit differs, or the key is sent LSb first, mode_active_o stays 0. The detector then goes back to idle: a further correct key sent without a new high-low pin pulse does not give entry.
- R4: Serial clock rising edges that arrive during the pre-key wait are not taken as key bits.
- R5: Serial clock edges within POST_CYC cycles of entry give no cmd_edge_o. Each later rising edge gives exactly one cycle of cmd_edge_o, with cmd_bit_o carrying the data line. cmd_edge_o is never 1 while mode_active_o is 0.
- R6: When the pin drops low while the mode is active, mode_active_o goes to 0 on the third rising clock edge after the drop. While the pin stays high, the mode is kept.
- R7: If the pin goes high during key collection, the collection is aborted, and the high-low pulse counts as a new opening pulse.
- R8: Serial edges between the 32nd key bit and the pin going high are ignored and do not disturb entry.
- R9: A key sent without a preceding high-low pulse (the pin low ever since reset) does not give entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vpp_hi_i | input | 1 | Logic level of the reset/programming-voltage pin |
| ser_clk_i | input | 1 | Serial clock line |
| ser_dat_i | input | 1 | Serial data line |
| mode_active_o | output | 1 | Program/verify mode is active |
| cmd_edge_o | output | 1 | One-cycle pulse for each accepted serial clock rising edge after the settle window |
| cmd_bit_o | output | 1 | Synchronized data bit that goes with cmd_edge_o |

## Verification
mode_active_o follows a pin change on the third rising clock edge: two edges for the synchronizer and one for the state register. The bench drives the pin on a falling edge and samples on falling edges. For both entry and exit it checks that the old value still holds two falling edges after the drive and that the new value is present on the third. cmd_edge_o pulses two clock edges after a serial clock rise. A monitor counts these pulses, so the bench compares the count only after each serial bit has fully completed. Pre-key and settle timing are tested by placing serial edges well inside and well outside the PRE_CYC and POST_CYC windows, with margins of several cycles rather than on the exact cycle.

// File: rtl/entry_key_pkg.sv
package entry_key_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PULSE_HI = 3'd1,
        ST_GAP      = 3'd2,
        ST_KEY      = 3'd3,
        ST_CHECK    = 3'd4,
        ST_ARM      = 3'd5,
        ST_SETTLE   = 3'd6,
        ST_ACTIVE   = 3'd7
    } entry_state_t;

    localparam logic [31:0] DEFAULT_ENTRY_KEY = 32'h4D43_4851;

endpackage

// File: rtl/entry_sync.sv
// Multi-stage synchronizer for a vector of slow asynchronous lines.
module entry_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else if (s == 0) begin
                    stg[s] <= d_i;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/entry_delay_cnt.sv
// Saturating wait counter: done once LIMIT cycles have been counted since clear.
module entry_delay_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/entry_key_shift.sv
// Collects KEY_W bits MSb first and flags a full word and a key match.
module entry_key_shift #(
    parameter int              KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY  = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic full_o,
    output logic match_o
);
    localparam int BC_W = $clog2(KEY_W + 1);
    localparam logic [BC_W-1:0] FULL_CNT = BC_W'(KEY_W);

    logic [KEY_W-1:0] word_q;
    logic [BC_W-1:0]  nbits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            nbits_q <= '0;
        end else if (clear_i) begin
            word_q  <= '0;
            nbits_q <= '0;
        end else if (shift_i && (nbits_q != FULL_CNT)) begin
            word_q  <= {word_q[KEY_W-2:0], bit_i};
            nbits_q <= nbits_q + 1'b1;
        end
    end

    assign full_o  = (nbits_q == FULL_CNT);
    assign match_o = full_o && (word_q == KEY);
endmodule

// File: rtl/entry_key_detector.sv
// Program/verify mode entry detector: pin pulse, MSb-first key, pin hold, settle lockout.
module entry_key_detector
    import entry_key_pkg::*;
#(
    parameter int               KEY_W       = 32,
    parameter logic [KEY_W-1:0] ENTRY_KEY   = DEFAULT_ENTRY_KEY,
    parameter int               PRE_CYC     = 16,
    parameter int               POST_CYC    = 16,
    parameter int               SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vpp_hi_i,
    input  logic ser_clk_i,
    input  logic ser_dat_i,
    output logic mode_active_o,
    output logic cmd_edge_o,
    output logic cmd_bit_o
);
    localparam int NLINES = 3;

    entry_state_t state_q, state_d;

    logic [NLINES-1:0] lines_s;
    logic pin_s, sclk_s, sdat_s, sclk_prev_q, sclk_rise;
    logic pre_done, post_done, key_full, key_match;

    entry_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({vpp_hi_i, ser_clk_i, ser_dat_i}),
        .q_o   (lines_s)
    );

    assign pin_s  = lines_s[2];
    assign sclk_s = lines_s[1];
    assign sdat_s = lines_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign sclk_rise = sclk_s && !sclk_prev_q;

    entry_delay_cnt #(.LIMIT(PRE_CYC)) u_pre_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q != ST_GAP),
        .done_o  (pre_done)
    );

    entry_delay_cnt #(.LIMIT(POST_CYC)) u_settle_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q != ST_SETTLE),
        .done_o  (post_done)
    );

    entry_key_shift #(.KEY_W(KEY_W), .KEY(ENTRY_KEY)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_GAP),
        .shift_i (sclk_rise && (state_q == ST_KEY)),
        .bit_i   (sdat_s),
        .full_o  (key_full),
        .match_o (key_match)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (pin_s) state_d = ST_PULSE_HI;
            ST_PULSE_HI: if (!pin_s) state_d = ST_GAP;
            ST_GAP: begin
                if (pin_s)         state_d = ST_PULSE_HI;
                else if (pre_done) state_d = ST_KEY;
            end
            ST_KEY: begin
                if (pin_s)         state_d = ST_PULSE_HI;
                else if (key_full) state_d = ST_CHECK;
            end
            ST_CHECK:    state_d = key_match ? ST_ARM : ST_IDLE;
            ST_ARM:      if (pin_s) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!pin_s)         state_d = ST_IDLE;
                else if (post_done) state_d = ST_ACTIVE;
            end
            ST_ACTIVE:   if (!pin_s) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mode_active_o = 1'b0;
        cmd_edge_o    = 1'b0;
        unique case (state_q)
            ST_SETTLE: mode_active_o = 1'b1;
            ST_ACTIVE: begin
                mode_active_o = 1'b1;
                cmd_edge_o    = sclk_rise;
            end
            default: ;
        endcase
        cmd_bit_o = sdat_s;
    end
endmodule

// File: rtl/entry_key_detector_chk.sv
module entry_key_detector_chk
    import entry_key_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         pin_s,
    input entry_state_t state,
    input logic         mode_active,
    input logic         cmd_edge
);
    AST_ENTRY_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> $past(pin_s)); // R2

    AST_ENTRY_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> $past(state) == ST_ARM); // R3

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && !pin_s) |=> !mode_active); // R6

    AST_EDGE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_edge |-> mode_active); // R5

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_edge |=> !cmd_edge); // R5

    AST_NO_EDGE_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |=> !cmd_edge); // R5

    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> (!mode_active && !cmd_edge)); // R1
endmodule

bind entry_key_detector entry_key_detector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_s       (pin_s),
    .state       (state_q),
    .mode_active (mode_active_o),
    .cmd_edge    (cmd_edge_o)
);

// File: tb/test_entry_key_detector.sv
module test_entry_key_detector;
    localparam int CLK_PERIOD = 10;
    localparam int PRE  = 20;
    localparam int POST = 30;
    localparam logic [31:0] KEY = 32'h4D43_4851;

    // {key, msb_first, expect_active}
    localparam int NVEC = 7;
    localparam logic [33:0] VEC [NVEC] = '{
        {32'h4D43_4851, 1'b1, 1'b1},
        {32'h4D43_4851, 1'b0, 1'b0},
        {32'h4D43_4850, 1'b1, 1'b0},
        {32'hCD43_4851, 1'b1, 1'b0},
        {32'h0000_0000, 1'b1, 1'b0},
        {32'hFFFF_FFFF, 1'b1, 1'b0},
        {32'h4D43_4851, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vpp = 1'b0, sclk = 1'b0, sdat = 1'b0;
    logic mode_active, cmd_edge, cmd_bit;
    int n_run = 0, n_fail = 0, n_edges = 0;
    logic last_bit = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    entry_key_detector #(.PRE_CYC(PRE), .POST_CYC(POST)) i_entry_key_detector (
        .clk           (clk),
        .rst_n         (rst_n),
        .vpp_hi_i      (vpp),
        .ser_clk_i     (sclk),
        .ser_dat_i     (sdat),
        .mode_active_o (mode_active),
        .cmd_edge_o    (cmd_edge),
        .cmd_bit_o     (cmd_bit)
    );

    always @(posedge clk) begin
        if (cmd_edge) begin
            n_edges  <= n_edges + 1;
            last_bit <= cmd_bit;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk) vpp = v;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) sdat = b;
        wait_n(2);
        sclk = 1'b1;
        wait_n(3);
        sclk = 1'b0;
        wait_n(1);
    endtask

    task automatic send_key(input logic [31:0] k, input logic msb_first);
        for (int i = 0; i < 32; i++)
            send_bit(msb_first ? k[31-i] : k[i]);
    endtask

    task automatic open_pulse();
        set_pin(1'b1);
        wait_n(4);
        set_pin(1'b0);
        wait_n(PRE + 8);
    endtask

    task automatic leave_mode();
        set_pin(1'b0);
        wait_n(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_n(3);
        check("R1 mode in reset", {31'b0, mode_active}, 32'd0);
        check("R1 edge in reset", {31'b0, cmd_edge}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        wait_n(2);
        check("R1 mode after reset", {31'b0, mode_active}, 32'd0);

        // R9: key without opening pulse
        send_key(KEY, 1'b1);
        set_pin(1'b1);
        wait_n(8);
        check("R9 no pulse no entry", {31'b0, mode_active}, 32'd0);
        leave_mode();

        // R2 / R3: vector table
        for (int v = 0; v < NVEC; v++) begin
            open_pulse();
            send_key(VEC[v][33:2], VEC[v][1]);
            set_pin(1'b1);
            wait_n(8);
            check(VEC[v][0] ? "R2 table entry" : "R3 table reject",
                  {31'b0, mode_active}, {31'b0, VEC[v][0]});
            leave_mode();
        end

        // R2: entry latency, R6: hold and drop latency
        open_pulse();
        send_key(KEY, 1'b1);
        set_pin(1'b1);
        wait_n(2);
        check("R2 not yet active", {31'b0, mode_active}, 32'd0);
        wait_n(1);
        check("R2 active on third edge", {31'b0, mode_active}, 32'd1);
        wait_n(200);
        check("R6 held while pin high", {31'b0, mode_active}, 32'd1);
        set_pin(1'b0);
        wait_n(2);
        check("R6 still active", {31'b0, mode_active}, 32'd1);
        wait_n(1);
        check("R6 cleared on third edge", {31'b0, mode_active}, 32'd0);
        wait_n(4);

        // R3: after mismatch, a correct key without new pulse gives no entry
        open_pulse();
        send_key(32'h1234_5678, 1'b1);
        wait_n(4);
        send_key(KEY, 1'b1);
        set_pin(1'b1);
        wait_n(8);
        check("R3 idle after mismatch", {31'b0, mode_active}, 32'd0);
        leave_mode();

        // R4: edges in the pre-key wait are not shifted
        set_pin(1'b1);
        wait_n(4);
        set_pin(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        wait_n(PRE + 8);
        send_key(KEY, 1'b1);
        set_pin(1'b1);
        wait_n(8);
        check("R4 gap edges ignored", {31'b0, mode_active}, 32'd1);
        leave_mode();

        // R7: pin high during collection restarts
        open_pulse();
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        set_pin(1'b1);
        wait_n(6);
        set_pin(1'b0);
        wait_n(PRE + 8);
        send_key(KEY, 1'b1);
        set_pin(1'b1);
        wait_n(8);
        check("R7 restart after abort", {31'b0, mode_active}, 32'd1);
        leave_mode();

        // R8: extra edges before pin rise, R5: settle lockout then pass
        open_pulse();
        send_key(KEY, 1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        set_pin(1'b1);
        wait_n(5);
        check("R8 entry despite extra bits", {31'b0, mode_active}, 32'd1);
        send_bit(1'b1);
        wait_n(2);
        check("R5 no edge in settle", n_edges, 32'd0);
        wait_n(POST + 10);
        send_bit(1'b1);
        wait_n(2);
        check("R5 one edge after settle", n_edges, 32'd1);
        check("R5 edge bit", {31'b0, last_bit}, 32'd1);
        send_bit(1'b0);
        wait_n(2);
        check("R5 second edge", n_edges, 32'd2);
        check("R5 second bit", {31'b0, last_bit}, 32'd0);
        leave_mode();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule